// File: doc/BRIEF.md
# SD Card Power-Up Clock Burst Sequencer

Before it sends its first command, an SD host has to give a newly powered card a run of clock cycles. This block produces that run. Software starts it by writing 1 to a control bit, `init_active`. The block holds that bit high while it counts a fixed number of SD-clock periods, 80 by default, and then clears the bit by itself. While the burst runs, the SD-clock enable is forced on, so automatic clock gating cannot stop the card clock. The CMD line is held in its idle (high) state for the same period.

Command requests do not have to wait for the bit to clear. If a command-start request arrives during the burst, the block keeps it. It lets the command go on the first SD-clock period after the last burst clock, so the command's bit stream never overlaps the burst. When no burst is running and nothing is waiting, a request passes straight through in the same cycle. Elsewhere in the host, the clock divider produces `sdclk_tick` once per SD-clock period, and the command serializer acts on `cmd_release`.

Top module: `sd_init_burst`

## Requirements
- R1: After an accepted start, `init_active` is high for exactly 80 cycles of `sdclk_tick`. It reads 0 in the clock cycle that follows the 80th tick. Between ticks it does not change.
- R2: A software write with data 0 never changes `init_active`. A write of 1 while the bit is already 1 does not restart or lengthen the burst.
- R3: A write of 1 is ignored whenever `cmd_inhibit` or `dat_inhibit` is high in the same cycle.
- R4: While `init_active` is high, `cmd_release` stays 0. A request taken during the burst gives a single-cycle `cmd_release` on the first `sdclk_tick` after `init_active` has cleared.
- R5: `sdclk_en` is 1 for the whole burst, even when `auto_gate_en` is 0.
- R6: Outside the burst, `sdclk_en` equals `auto_gate_en` in the same cycle.
- R7: When no burst is running and no request is waiting, `cmd_release` equals `cmd_start_req` in the same cycle.
- R8: `cmd_idle_hold` is 1 exactly while the burst runs and 0 otherwise.
- R9: Reset clears `init_active`, the burst count and any waiting command request.
- R10: Several requests during one burst merge into one `cmd_release` pulse after the burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| sdclk_tick | input | 1 | One-cycle enable marking each SD-clock period |
| auto_gate_en | input | 1 | Clock enable requested by automatic gating |
| cmd_inhibit | input | 1 | Command line busy flag |
| dat_inhibit | input | 1 | Data lines busy flag |
| sw_wr | input | 1 | Software write strobe for the control bit |
| sw_wdata | input | 1 | Value written to the control bit |
| cmd_start_req | input | 1 | Request to start sending a command |
| sdclk_en | output | 1 | Enable for the SD clock driven to the card |
| cmd_release | output | 1 | Strobe that lets the command serializer start |
| cmd_idle_hold | output | 1 | Holds the CMD line high during the burst |
| init_active | output | 1 | Readable control bit; 1 while the burst runs |

## Verification
A wrong burst count shows on `init_active` when the burst ends. The bit clears one SD-clock tick too early or too late, so the bench counts every tick seen while the bit is high. A waiting request that is lost or kept too long shows as a missing or repeated `cmd_release` on the first tick after the burst, within two SD-clock periods of the end. A wrong gating mux or a pass-through path with extra delay shows in the same cycle on `sdclk_en` or `cmd_release`, and the idle-state vector table catches it.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;
  localparam int unsigned BURST_LEN_DEFAULT = 80;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } burst_st_e;
endpackage

// File: rtl/sdinit_burst_ctrl.sv
module sdinit_burst_ctrl
  import sd_init_pkg::*;
#(
  parameter int unsigned BURST_LEN = BURST_LEN_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdclk_tick,
  input  logic cmd_inhibit,
  input  logic dat_inhibit,
  input  logic sw_wr,
  input  logic sw_wdata,
  output logic active
);
  localparam int unsigned CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BURST_LEN - 1);

  burst_st_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             start_ok;
  logic             last_tick;

  // A start is taken only when the bit is idle and both lines are free.
  always_comb begin
    start_ok  = sw_wr && sw_wdata && (state_q == ST_IDLE) &&
                !cmd_inhibit && !dat_inhibit;
    last_tick = (state_q == ST_BURST) && sdclk_tick && (cnt_q == LAST_CNT);
    cnt_en    = start_ok || ((state_q == ST_BURST) && sdclk_tick);
    cnt_d     = start_ok ? '0 : cnt_q + 1'b1;
    state_d   = state_q;
    case (state_q)
      ST_IDLE:  if (start_ok)  state_d = ST_BURST;
      ST_BURST: if (last_tick) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign active = (state_q == ST_BURST);

  AST_CLEARS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sdclk_tick && cnt_q == LAST_CNT) |=> !active); // R1
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sdclk_tick) |=> (active && $stable(cnt_q))); // R1
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < CNT_W'(BURST_LEN))); // R1
  AST_WRITE0_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && sw_wr && !sw_wdata) |=> !active); // R2
  AST_BUSY_REFUSES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && (cmd_inhibit || dat_inhibit)) |=> !active); // R3
endmodule

// File: rtl/sdinit_cmd_gate.sv
module sdinit_cmd_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic sdclk_tick,
  input  logic cmd_start_req,
  input  logic auto_gate_en,
  output logic sdclk_en,
  output logic cmd_release,
  output logic cmd_idle_hold
);
  logic pend_q, pend_d;
  logic pend_en;
  logic pend_fire;

  always_comb begin
    pend_fire   = !active && pend_q && sdclk_tick;
    cmd_release = !active && (pend_q ? sdclk_tick : cmd_start_req);
    pend_en     = (active && cmd_start_req) || pend_fire;
    pend_d      = active && cmd_start_req;
    sdclk_en    = active ? 1'b1 : auto_gate_en;
    cmd_idle_hold = active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  AST_PEND_KEPT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && active) |=> pend_q); // R10
  AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !active && sdclk_tick) |=> !pend_q); // R4
endmodule

// File: rtl/sd_init_burst.sv
module sd_init_burst
  import sd_init_pkg::*;
#(
  parameter int unsigned BURST_LEN = BURST_LEN_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdclk_tick,
  input  logic auto_gate_en,
  input  logic cmd_inhibit,
  input  logic dat_inhibit,
  input  logic sw_wr,
  input  logic sw_wdata,
  input  logic cmd_start_req,
  output logic sdclk_en,
  output logic cmd_release,
  output logic cmd_idle_hold,
  output logic init_active
);
  logic active;

  sdinit_burst_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdclk_tick  (sdclk_tick),
    .cmd_inhibit (cmd_inhibit),
    .dat_inhibit (dat_inhibit),
    .sw_wr       (sw_wr),
    .sw_wdata    (sw_wdata),
    .active      (active)
  );

  sdinit_cmd_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (active),
    .sdclk_tick    (sdclk_tick),
    .cmd_start_req (cmd_start_req),
    .auto_gate_en  (auto_gate_en),
    .sdclk_en      (sdclk_en),
    .cmd_release   (cmd_release),
    .cmd_idle_hold (cmd_idle_hold)
  );

  assign init_active = active;

  AST_CLK_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    init_active |-> sdclk_en); // R5
  AST_NO_RELEASE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    init_active |-> !cmd_release); // R4
  AST_CMD_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_active |-> cmd_idle_hold); // R8
endmodule

// File: tb/sd_init_burst_bench.sv
module sd_init_burst_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BURST = 80;

  logic clk = 1'b0;
  logic rst_n;
  logic sdclk_tick, auto_gate_en, cmd_inhibit, dat_inhibit;
  logic sw_wr, sw_wdata, cmd_start_req;
  logic sdclk_en, cmd_release, cmd_idle_hold, init_active;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_init_burst u_sd_init_burst (
    .clk(clk), .rst_n(rst_n), .sdclk_tick(sdclk_tick),
    .auto_gate_en(auto_gate_en), .cmd_inhibit(cmd_inhibit),
    .dat_inhibit(dat_inhibit), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .cmd_start_req(cmd_start_req), .sdclk_en(sdclk_en),
    .cmd_release(cmd_release), .cmd_idle_hold(cmd_idle_hold),
    .init_active(init_active)
  );

  // {auto_gate_en, cmd_start_req, expected sdclk_en, expected cmd_release}
  localparam logic [3:0] VEC [8] = '{
    4'b0000, 4'b1010, 4'b0101, 4'b1111,
    4'b1010, 4'b0000, 4'b1111, 4'b0101
  };

  task automatic chk(input int act, input int exp, input string req);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive inputs just after a rising edge, then wait for the falling edge.
  task automatic cyc(input logic tk, input logic rq);
    @(posedge clk); #1;
    sdclk_tick = tk; cmd_start_req = rq;
    sw_wr = 1'b0; sw_wdata = 1'b0;
    @(negedge clk);
  endtask

  task automatic sw_write(input logic v);
    @(posedge clk); #1;
    sdclk_tick = 1'b0; cmd_start_req = 1'b0;
    sw_wr = 1'b1; sw_wdata = v;
    @(negedge clk);
  endtask

  // Tick until the bit clears; returns the number of ticks taken while active.
  task automatic run_to_idle(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      cyc(1'b1, 1'b0);
      n++;
      chk(sdclk_en, 1, "R5 clock forced during burst");
      chk(cmd_release, 0, "R4 no release in burst");
      chk(cmd_idle_hold, 1, "R8 cmd held during burst");
      cyc(1'b0, 1'b0);
      if (!init_active) break;
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0;
    sdclk_tick = 0; auto_gate_en = 0; cmd_inhibit = 0; dat_inhibit = 0;
    sw_wr = 0; sw_wdata = 0; cmd_start_req = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(init_active, 0, "R9 reset bit");
    chk(cmd_idle_hold, 0, "R8 idle after reset");

    // Idle pass-through table (R6, R7)
    foreach (VEC[i]) begin
      @(posedge clk); #1;
      auto_gate_en = VEC[i][3]; cmd_start_req = VEC[i][2];
      @(negedge clk);
      chk(sdclk_en, VEC[i][1], "R6 gating follows request");
      chk(cmd_release, VEC[i][0], "R7 direct release when idle");
    end
    auto_gate_en = 1'b0;

    // R2 write of 0 while idle
    sw_write(1'b0);
    cyc(1'b0, 1'b0);
    chk(init_active, 0, "R2 write0 idle");

    // R3 refused while busy
    cmd_inhibit = 1'b1; sw_write(1'b1); cyc(1'b0, 1'b0);
    chk(init_active, 0, "R3 cmd_inhibit refuses");
    cmd_inhibit = 1'b0; dat_inhibit = 1'b1; sw_write(1'b1); cyc(1'b0, 1'b0);
    chk(init_active, 0, "R3 dat_inhibit refuses");
    dat_inhibit = 1'b0;

    // R1/R4/R10 burst with requests taken during it
    sw_write(1'b1);
    cyc(1'b0, 1'b0);
    chk(init_active, 1, "R1 start accepted");
    chk(cmd_idle_hold, 1, "R8 hold on start");
    for (int k = 0; k < 5; k++) begin
      cyc(1'b1, 1'b0);
      cyc(1'b0, k == 1 || k == 3);
      chk(cmd_release, 0, "R4 request held in burst");
    end
    run_to_idle(n);
    chk(n + 5, BURST, "R1 burst tick count");
    chk(cmd_idle_hold, 0, "R8 hold released");
    chk(cmd_release, 0, "R4 no release before tick");
    cyc(1'b0, 1'b0);
    chk(cmd_release, 0, "R4 wait for tick");
    cyc(1'b1, 1'b0);
    chk(cmd_release, 1, "R4 release on first tick");
    cyc(1'b0, 1'b0);
    chk(cmd_release, 0, "R4 single cycle");
    cyc(1'b1, 1'b0);
    chk(cmd_release, 0, "R10 merged into one release");

    // R2 rewrite of 1 and write of 0 during burst
    sw_write(1'b1);
    for (int k = 0; k < 40; k++) begin cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); end
    sw_write(1'b1);
    sw_write(1'b0);
    cyc(1'b0, 1'b0);
    chk(init_active, 1, "R2 write0 in burst");
    run_to_idle(n);
    chk(n + 40, BURST, "R2 rewrite does not restart");
    chk(init_active, 0, "R1 cleared");

    // R9 reset mid-burst with a waiting request
    sw_write(1'b1);
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b1);
    do_reset();
    @(negedge clk);
    chk(init_active, 0, "R9 reset clears bit");
    cyc(1'b1, 1'b0);
    chk(cmd_release, 0, "R9 reset drops request");

    // R9 counter restarts from zero after reset
    sw_write(1'b1);
    cyc(1'b0, 1'b0);
    run_to_idle(n);
    chk(n, BURST, "R9 full burst after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule